// File: doc/BRIEF.md
# Segmented Two-Way Address Translation Lookup

This block maps a 32-bit effective address to a physical address in two steps. The top four address bits pick one of sixteen segment registers. That register provides a 24-bit virtual segment identifier and two protection keys, one for supervisor mode and one for user mode. The identifier, together with the page-number bits of the address, is then looked up in a two-way set-associative translation buffer. In the address, bit 0 is the most significant bit. In the vector notation used below, EA[0] is `req_ea[31]`.

A lookup request is registered on a clock edge. Hit or miss, the physical address, the four storage-attribute bits and the two fault flags are then produced combinationally during the following cycle. A protection fault or a changed-bit fault holds back the page number and the attributes.

Software fills segment registers and buffer entries through a one-cycle write port. The same port can invalidate a whole set. Each set keeps one replacement bit that names the least-recently-used way.

Top module: `seg_tlb_xlate`

## Requirements
- R1: `req_ea[31:28]` selects the segment register. On a clean hit, `rsp_paddr` is the entry's 20-bit real page number followed by `req_ea[11:0]`.
- R2: The set is selected by EA[15–19], which is `req_ea[16:12]` in the default configuration and `req_ea[12 +: SET_BITS]` in general. Both ways of the selected set are compared in the same cycle, and an entry may be written into either way.
- R3: An entry hits only if it is valid and all of the following match: its stored segment identifier matches the identifier from the selected segment register, its 6-bit abbreviated page index matches `req_ea[27:22]`, and its extra page bits match `req_ea[21:12+SET_BITS]`.
- R4: The protection key is the segment's user key when `req_user`=1, otherwise its supervisor key. With key 0, protection codes 0, 1 and 2 allow reads and writes, and code 3 allows reads only. With key 1, code 0 denies every access, codes 1 and 3 allow reads only, and code 2 allows reads and writes. A store (`req_kind`=1) is a write. A load (0) or a fetch (2) is a read. A denied hit sets `rsp_prot_fault`.
- R5: A store that hits an entry with changed bit 0 and passes R4 sets `rsp_chg_fault`. `rsp_prot_fault` and `rsp_chg_fault` are never set together.
- R6: When a request misses or faults, `rsp_paddr` and `rsp_wimg` are zero. When a hit is clean, `rsp_wimg` carries the entry's attribute bits.
- R7: `rsp_valid` and all results in a cycle belong to the request registered at the preceding clock edge. Without a request, `rsp_valid` is 0.
- R8: Each set's replacement bit points at the way that was not last used, where a hit or a write both count as use. An entry write with `wr_use_lru`=1 goes to that way instead of `wr_way`, and the written entry becomes valid.
- R9: An invalidate operation (`wr_op`=2) clears the valid bits of both ways in the set named by `wr_page`. Other sets are unaffected.
- R10: After reset, every entry is invalid and every lookup misses. Segment register contents are undefined until they are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_ea | input | 32 | Effective address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| req_user | input | 1 | 1 = user privilege |
| wr_en | input | 1 | Write-port strobe |
| wr_op | input | 2 | 0 segment register, 1 buffer entry, 2 invalidate set |
| wr_page | input | 20 | Page part of the target address (`req_ea[31:12]` layout) |
| wr_way | input | 1 | Way for an explicit entry write |
| wr_use_lru | input | 1 | Use the replacement bit instead of `wr_way` |
| wr_vsid | input | VSID_W | Segment identifier (segment write and entry tag) |
| wr_ks | input | 1 | Supervisor key for a segment write |
| wr_kp | input | 1 | User key for a segment write |
| wr_rpn | input | RPN_W | Real page number |
| wr_c | input | 1 | Changed bit |
| wr_wimg | input | 4 | Storage attributes |
| wr_pp | input | 2 | Protection code |
| rsp_valid | output | 1 | Result belongs to a request |
| rsp_hit | output | 1 | Lookup hit |
| rsp_prot_fault | output | 1 | Protection fault |
| rsp_chg_fault | output | 1 | Changed-bit fault |
| rsp_paddr | output | RPN_W+12 | Physical address |
| rsp_wimg | output | 4 | Attributes of the hit |

## Verification
The bench builds the block with `SET_BITS`=3, which gives 8 sets and 7 extra page bits, and keeps the 24-bit identifier and the 20-bit page number. With only 8 sets, it can fill every way of every set. It then looks up each entry under all three access kinds and both privilege levels, which covers every protection code against both key values. The small set count also keeps the single-field miss probes, the set invalidation and a two-step replacement sequence short.

// File: rtl/seg_tlb_pkg.sv
package seg_tlb_pkg;
  localparam int EA_W     = 32;
  localparam int OFF_W    = 12;
  localparam int SEG_W    = 4;
  localparam int API_W    = 6;
  localparam int PINDEX_W = EA_W - OFF_W - SEG_W - API_W;
  localparam int PAGE_W   = EA_W - OFF_W;
  localparam int NWAY     = 2;
  localparam int ATTR_W   = 4;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    WOP_SEG   = 2'd0,
    WOP_ENTRY = 2'd1,
    WOP_KILL  = 2'd2,
    WOP_NONE  = 2'd3
  } wop_e;

  typedef struct packed {
    logic [1:0]        pp;
    logic              chg;
    logic [ATTR_W-1:0] wimg;
  } attr_t;
endpackage

// File: rtl/seg_tlb_rst_sync.sv
module seg_tlb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/seg_tlb_segfile.sv
module seg_tlb_segfile #(
  parameter int NSEG   = 16,
  parameter int VSID_W = 24,
  localparam int IDX_W = $clog2(NSEG)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  w_idx,
  input  logic [VSID_W-1:0] w_vsid,
  input  logic              w_ks,
  input  logic              w_kp,
  input  logic [IDX_W-1:0]  r_idx,
  output logic [VSID_W-1:0] r_vsid,
  output logic              r_ks,
  output logic              r_kp
);
  localparam int ROW_W = VSID_W + 2;

  logic [ROW_W-1:0] row_q [NSEG];

  // storage rows carry no reset: contents are undefined until written
  always_ff @(posedge clk) begin
    if (we) row_q[w_idx] <= {w_vsid, w_ks, w_kp};
  end

  assign {r_vsid, r_ks, r_kp} = row_q[r_idx];
endmodule

// File: rtl/seg_tlb_ways.sv
module seg_tlb_ways #(
  parameter int SET_BITS = 5,
  parameter int TAG_W    = 35,
  parameter int DATA_W   = 27,
  localparam int NSET    = 1 << SET_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lk_en,
  input  logic [SET_BITS-1:0] lk_idx,
  input  logic [TAG_W-1:0]    lk_tag,
  output logic [1:0]          hit_vec,
  output logic [DATA_W-1:0]   hit_data,
  input  logic                wr_en,
  input  logic                wr_kill,
  input  logic [SET_BITS-1:0] wr_idx,
  input  logic                wr_way,
  input  logic                wr_use_lru,
  input  logic [TAG_W-1:0]    wr_tag,
  input  logic [DATA_W-1:0]   wr_data
);
  import seg_tlb_pkg::*;

  logic [NWAY-1:0][NSET-1:0]   vld_q, vld_d;
  logic [NSET-1:0]             lru_q, lru_d;
  logic [NWAY-1:0][TAG_W-1:0]  rd_tag;
  logic [NWAY-1:0][DATA_W-1:0] rd_data;
  logic                        victim;
  logic                        fill;

  assign victim = wr_use_lru ? lru_q[wr_idx] : wr_way;
  assign fill   = wr_en && !wr_kill;

  for (genvar w = 0; w < NWAY; w++) begin : g_way
    logic [TAG_W-1:0]  tag_q [NSET];
    logic [DATA_W-1:0] dat_q [NSET];
    logic              we_w;

    assign we_w = fill && (victim == w[0]);

    always_ff @(posedge clk) begin
      if (we_w) begin
        tag_q[wr_idx] <= wr_tag;
        dat_q[wr_idx] <= wr_data;
      end
    end

    assign rd_tag[w]  = tag_q[lk_idx];
    assign rd_data[w] = dat_q[lk_idx];
    assign hit_vec[w] = lk_en && vld_q[w][lk_idx] && (rd_tag[w] == lk_tag);
  end

  // way 0 wins if both ways ever match
  assign hit_data = hit_vec[0] ? rd_data[0] : rd_data[1];

  always_comb begin
    vld_d = vld_q;
    if (wr_en) begin
      if (wr_kill) begin
        for (int w = 0; w < NWAY; w++) vld_d[w][wr_idx] = 1'b0;
      end else begin
        vld_d[victim][wr_idx] = 1'b1;
      end
    end
  end

  always_comb begin
    lru_d = lru_q;
    if (wr_en) begin
      if (!wr_kill) lru_d[wr_idx] = ~victim;
    end else if (|hit_vec) begin
      lru_d[lk_idx] = hit_vec[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      lru_q <= '0;
    end else begin
      vld_q <= vld_d;
      lru_q <= lru_d;
    end
  end

  assert_kill_clears_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_kill) |=> (!vld_q[0][$past(wr_idx)] && !vld_q[1][$past(wr_idx)]));

  assert_fill_marks_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_kill) |=> vld_q[$past(victim)][$past(wr_idx)]);

  assert_hit_moves_lru_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && (|hit_vec)) |=> (lru_q[$past(lk_idx)] == $past(hit_vec[0])));
endmodule

// File: rtl/seg_tlb_perm.sv
module seg_tlb_perm
  import seg_tlb_pkg::*;
(
  input  logic  hit,
  input  logic  key,
  input  acc_e  kind,
  input  attr_t attr,
  output logic  prot_fault,
  output logic  chg_fault,
  output logic  release_ok
);
  logic rd_ok, wr_ok, is_wr;

  always_comb begin
    if (!key) begin
      rd_ok = 1'b1;
      wr_ok = (attr.pp != 2'd3);
    end else begin
      unique case (attr.pp)
        2'd0:    begin rd_ok = 1'b0; wr_ok = 1'b0; end
        2'd2:    begin rd_ok = 1'b1; wr_ok = 1'b1; end
        default: begin rd_ok = 1'b1; wr_ok = 1'b0; end
      endcase
    end
  end

  assign is_wr      = (kind == ACC_STORE);
  assign prot_fault = hit && (is_wr ? !wr_ok : !rd_ok);
  assign chg_fault  = hit && is_wr && wr_ok && !attr.chg;
  assign release_ok = hit && !prot_fault && !chg_fault;
endmodule

// File: rtl/seg_tlb_xlate.sv
module seg_tlb_xlate
  import seg_tlb_pkg::*;
#(
  parameter int SET_BITS = 5,
  parameter int VSID_W   = 24,
  parameter int RPN_W    = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [EA_W-1:0]         req_ea,
  input  logic [1:0]              req_kind,
  input  logic                    req_user,
  input  logic                    wr_en,
  input  logic [1:0]              wr_op,
  input  logic [PAGE_W-1:0]       wr_page,
  input  logic                    wr_way,
  input  logic                    wr_use_lru,
  input  logic [VSID_W-1:0]       wr_vsid,
  input  logic                    wr_ks,
  input  logic                    wr_kp,
  input  logic [RPN_W-1:0]        wr_rpn,
  input  logic                    wr_c,
  input  logic [ATTR_W-1:0]       wr_wimg,
  input  logic [1:0]              wr_pp,
  output logic                    rsp_valid,
  output logic                    rsp_hit,
  output logic                    rsp_prot_fault,
  output logic                    rsp_chg_fault,
  output logic [RPN_W+OFF_W-1:0]  rsp_paddr,
  output logic [ATTR_W-1:0]       rsp_wimg
);
  localparam int XTRA_W = PINDEX_W - SET_BITS;
  localparam int TAG_W  = VSID_W + API_W + XTRA_W;
  localparam int DATA_W = RPN_W + $bits(attr_t);
  localparam int NSEG   = 1 << SEG_W;
  // field positions inside the page part of the address
  localparam int P_IDX  = 0;
  localparam int P_XTRA = SET_BITS;
  localparam int P_API  = PINDEX_W;
  localparam int P_SEG  = PINDEX_W + API_W;

  logic rst_sn;

  seg_tlb_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  // registered request
  logic              rv_q, rv_d;
  logic [EA_W-1:0]   ea_q, ea_d;
  acc_e              kind_q, kind_d;
  logic              user_q, user_d;

  always_comb begin
    rv_d   = req_valid;
    ea_d   = ea_q;
    kind_d = kind_q;
    user_d = user_q;
    if (req_valid) begin
      ea_d   = req_ea;
      kind_d = acc_e'(req_kind);
      user_d = req_user;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      rv_q   <= 1'b0;
      ea_q   <= '0;
      kind_q <= ACC_LOAD;
      user_q <= 1'b0;
    end else begin
      rv_q   <= rv_d;
      ea_q   <= ea_d;
      kind_q <= kind_d;
      user_q <= user_d;
    end
  end

  // address field split
  logic [PAGE_W-1:0]   pg_q;
  logic [SEG_W-1:0]    seg_sel;
  logic [API_W-1:0]    api_q;
  logic [XTRA_W-1:0]   xtra_q;
  logic [SET_BITS-1:0] set_q;
  logic [OFF_W-1:0]    off_q;

  assign pg_q    = ea_q[EA_W-1:OFF_W];
  assign off_q   = ea_q[OFF_W-1:0];
  assign seg_sel = pg_q[P_SEG +: SEG_W];
  assign api_q   = pg_q[P_API +: API_W];
  assign xtra_q  = pg_q[P_XTRA +: XTRA_W];
  assign set_q   = pg_q[P_IDX +: SET_BITS];

  // write port decode
  wop_e wop;
  logic seg_we, ent_we, kill_we;

  assign wop     = wop_e'(wr_op);
  assign seg_we  = wr_en && (wop == WOP_SEG);
  assign ent_we  = wr_en && (wop == WOP_ENTRY);
  assign kill_we = wr_en && (wop == WOP_KILL);

  // segment register file
  logic [VSID_W-1:0] seg_vsid;
  logic              seg_ks, seg_kp;

  seg_tlb_segfile #(.NSEG(NSEG), .VSID_W(VSID_W)) u_seg (
    .clk    (clk),
    .we     (seg_we),
    .w_idx  (wr_page[P_SEG +: SEG_W]),
    .w_vsid (wr_vsid),
    .w_ks   (wr_ks),
    .w_kp   (wr_kp),
    .r_idx  (seg_sel),
    .r_vsid (seg_vsid),
    .r_ks   (seg_ks),
    .r_kp   (seg_kp)
  );

  // translation buffer
  attr_t               w_attr;
  logic [TAG_W-1:0]    lk_tag, w_tag;
  logic [DATA_W-1:0]   w_data, h_data;
  logic [1:0]          hit_vec;

  assign w_attr = '{pp: wr_pp, chg: wr_c, wimg: wr_wimg};
  assign lk_tag = {seg_vsid, api_q, xtra_q};
  assign w_tag  = {wr_vsid, wr_page[P_API +: API_W], wr_page[P_XTRA +: XTRA_W]};
  assign w_data = {wr_rpn, w_attr};

  seg_tlb_ways #(.SET_BITS(SET_BITS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_ways (
    .clk        (clk),
    .rst_n      (rst_sn),
    .lk_en      (rv_q),
    .lk_idx     (set_q),
    .lk_tag     (lk_tag),
    .hit_vec    (hit_vec),
    .hit_data   (h_data),
    .wr_en      (ent_we || kill_we),
    .wr_kill    (kill_we),
    .wr_idx     (wr_page[P_IDX +: SET_BITS]),
    .wr_way     (wr_way),
    .wr_use_lru (wr_use_lru),
    .wr_tag     (w_tag),
    .wr_data    (w_data)
  );

  // protection and changed-bit checks
  attr_t            h_attr;
  logic [RPN_W-1:0] h_rpn;
  logic             any_hit, key, prot_f, chg_f, rel_ok;

  assign {h_rpn, h_attr} = h_data;
  assign any_hit = |hit_vec;
  assign key     = user_q ? seg_kp : seg_ks;

  seg_tlb_perm u_perm (
    .hit        (any_hit),
    .key        (key),
    .kind       (kind_q),
    .attr       (h_attr),
    .prot_fault (prot_f),
    .chg_fault  (chg_f),
    .release_ok (rel_ok)
  );

  assign rsp_valid      = rv_q;
  assign rsp_hit        = any_hit;
  assign rsp_prot_fault = prot_f;
  assign rsp_chg_fault  = chg_f;
  assign rsp_paddr      = rel_ok ? {h_rpn, off_q} : '0;
  assign rsp_wimg       = rel_ok ? h_attr.wimg : '0;

  assert_rsp_follows_req_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    req_valid |=> rsp_valid);

  assert_idle_no_hit_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    !rsp_valid |-> !rsp_hit);

  assert_faults_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    !(rsp_prot_fault && rsp_chg_fault));

  assert_chg_only_store_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    rsp_chg_fault |-> (kind_q == ACC_STORE));

  assert_fault_needs_hit_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    (rsp_prot_fault || rsp_chg_fault) |-> rsp_hit);

  assert_blocked_is_quiet_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    (!rsp_hit || rsp_prot_fault || rsp_chg_fault) |-> (rsp_paddr == '0 && rsp_wimg == '0));

  assert_paddr_offset_R1: assert property (@(posedge clk) disable iff (!rst_sn)
    (rsp_hit && !rsp_prot_fault && !rsp_chg_fault) |-> (rsp_paddr[OFF_W-1:0] == off_q));
endmodule

// File: tb/seg_tlb_xlate_bench.sv
`timescale 1ns/1ps
module seg_tlb_xlate_bench;
  import seg_tlb_pkg::*;

  localparam int SB = 3;
  localparam int NS = 1 << SB;
  localparam int XW = PINDEX_W - SB;
  localparam int VW = 24;
  localparam int RW = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [31:0] req_ea = '0;
  logic [1:0] req_kind = '0;
  logic req_user = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_op = '0;
  logic [19:0] wr_page = '0;
  logic wr_way = 1'b0, wr_use_lru = 1'b0;
  logic [VW-1:0] wr_vsid = '0;
  logic wr_ks = 1'b0, wr_kp = 1'b0;
  logic [RW-1:0] wr_rpn = '0;
  logic wr_c = 1'b0;
  logic [3:0] wr_wimg = '0;
  logic [1:0] wr_pp = '0;
  logic rsp_valid, rsp_hit, rsp_prot_fault, rsp_chg_fault;
  logic [RW+11:0] rsp_paddr;
  logic [3:0] rsp_wimg;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  seg_tlb_xlate #(.SET_BITS(SB), .VSID_W(VW), .RPN_W(RW)) u_seg_tlb_xlate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ea(req_ea),
    .req_kind(req_kind), .req_user(req_user), .wr_en(wr_en), .wr_op(wr_op),
    .wr_page(wr_page), .wr_way(wr_way), .wr_use_lru(wr_use_lru),
    .wr_vsid(wr_vsid), .wr_ks(wr_ks), .wr_kp(wr_kp), .wr_rpn(wr_rpn),
    .wr_c(wr_c), .wr_wimg(wr_wimg), .wr_pp(wr_pp), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_prot_fault(rsp_prot_fault),
    .rsp_chg_fault(rsp_chg_fault), .rsp_paddr(rsp_paddr), .rsp_wimg(rsp_wimg)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run hung (actual cycles=%0d expected<100000)", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // entry recipe for set i, way w
  function automatic int e_seg(int i, int w);  return (i + 3*w) % 16; endfunction
  function automatic int e_api(int i, int w);  return (i*2 + w) % 64; endfunction
  function automatic int e_ext(int i, int w);  return (i*5 + w*11) % (1 << XW); endfunction
  function automatic int e_rpn(int i, int w);  return 32'h5A000 + i*16 + w; endfunction
  function automatic int e_pp(int i, int w);   return (i + w) % 4; endfunction
  function automatic int e_c(int i, int w);    return ((i >> 1) & 1) ^ w; endfunction
  function automatic int e_wimg(int i, int w); return (i*3 + w*5) % 16; endfunction
  function automatic int e_off(int i, int w);  return (i*37 + w*101) % 4096; endfunction
  function automatic logic [VW-1:0] s_vsid(int s); return VW'(32'h0A0000 + s*273); endfunction

  function automatic logic [31:0] mk_ea(int seg, int api, int ext, int idx, int off);
    return (32'(seg) << 28) | (32'(api) << 22) | (32'(ext) << (12 + SB)) |
           (32'(idx) << 12) | 32'(off);
  endfunction

  // expected {valid, hit, prot, chg, wimg, paddr}
  function automatic logic [39:0] expv(bit hit, int pp, int c, int key, int kind,
                                       int rpn, int wimg, int off);
    bit rd_ok, wr_ok, prot, chg;
    logic [31:0] pa;
    if (!hit) return {1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 32'h0};
    rd_ok = (key == 0) ? 1'b1 : (pp != 0);
    wr_ok = (key == 0) ? (pp != 3) : (pp == 2);
    prot  = (kind == 1) ? !wr_ok : !rd_ok;
    chg   = (kind == 1) && !prot && (c == 0);
    pa    = (32'(rpn) << 12) | 32'(off);
    if (prot || chg) return {1'b1, 1'b1, prot, chg, 4'h0, 32'h0};
    return {1'b1, 1'b1, 1'b0, 1'b0, 4'(wimg), pa};
  endfunction

  function automatic logic [39:0] exp_ent(int i, int w, int kind, int user);
    int s, key;
    s = e_seg(i, w);
    key = user ? ((s >> 1) & 1) : (s & 1);
    return expv(1'b1, e_pp(i, w), e_c(i, w), key, kind, e_rpn(i, w), e_wimg(i, w), e_off(i, w));
  endfunction

  task automatic check(bit ok, string tag, logic [39:0] act, logic [39:0] exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic look(logic [31:0] ea, int kind, int user, logic [39:0] exp, string tag);
    logic [39:0] act;
    @(negedge clk);
    req_valid = 1'b1; req_ea = ea; req_kind = 2'(kind); req_user = 1'(user);
    @(negedge clk);
    req_valid = 1'b0;
    act = {rsp_valid, rsp_hit, rsp_prot_fault, rsp_chg_fault, rsp_wimg, rsp_paddr};
    check(act === exp, tag, act, exp);
  endtask

  task automatic wr_seg(int s, logic [VW-1:0] v, bit ks, bit kp);
    @(negedge clk);
    wr_en = 1'b1; wr_op = 2'd0; wr_page = 20'(s) << 16; wr_vsid = v; wr_ks = ks; wr_kp = kp;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_ent(logic [31:0] ea, bit way, bit use_lru, logic [VW-1:0] v,
                        int rpn, int c, int wimg, int pp);
    @(negedge clk);
    wr_en = 1'b1; wr_op = 2'd1; wr_page = ea[31:12]; wr_way = way; wr_use_lru = use_lru;
    wr_vsid = v; wr_rpn = RW'(rpn); wr_c = 1'(c); wr_wimg = 4'(wimg); wr_pp = 2'(pp);
    @(negedge clk);
    wr_en = 1'b0; wr_use_lru = 1'b0;
  endtask

  task automatic kill_set(int idx);
    @(negedge clk);
    wr_en = 1'b1; wr_op = 2'd2; wr_page = 20'(idx);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  localparam logic [39:0] MISS = {1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 32'h0};

  initial begin
    logic [39:0] act;
    logic [31:0] ea_a, ea_b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 and R7: idle after reset, then every lookup misses
    act = {rsp_valid, rsp_hit, rsp_prot_fault, rsp_chg_fault, rsp_wimg, rsp_paddr};
    check(act === 40'h0, "R7 R10 reset idle", act, 40'h0);
    for (int i = 0; i < NS; i++)
      look(mk_ea(i, 5, i, i, 9), 0, 0, MISS, "R10 miss after reset");

    for (int s = 0; s < 16; s++) wr_seg(s, s_vsid(s), s[0], s[1]);

    // R2: fill both ways of every set by explicit way
    for (int i = 0; i < NS; i++)
      for (int w = 0; w < 2; w++)
        wr_ent(mk_ea(e_seg(i, w), e_api(i, w), e_ext(i, w), i, 0), 1'(w), 1'b0,
               s_vsid(e_seg(i, w)), e_rpn(i, w), e_c(i, w), e_wimg(i, w), e_pp(i, w));

    // R1 R2 R4 R5 R6: all kinds and privileges on every entry
    for (int i = 0; i < NS; i++)
      for (int w = 0; w < 2; w++)
        for (int k = 0; k < 3; k++)
          for (int u = 0; u < 2; u++)
            look(mk_ea(e_seg(i, w), e_api(i, w), e_ext(i, w), i, e_off(i, w)), k, u,
                 exp_ent(i, w, k, u), "R1 R2 R4 R5 R6 sweep");

    // R7: no request, no valid
    @(negedge clk);
    act = {rsp_valid, rsp_hit, rsp_prot_fault, rsp_chg_fault, rsp_wimg, rsp_paddr};
    check(act === 40'h0, "R7 idle cycle", act, 40'h0);

    // R3: single-field mismatches miss
    look(mk_ea(e_seg(1, 0) ^ 8, e_api(1, 0), e_ext(1, 0), 1, 4), 0, 0, MISS, "R3 segment id");
    look(mk_ea(e_seg(1, 0), e_api(1, 0) ^ 32, e_ext(1, 0), 1, 4), 0, 0, MISS, "R3 api");
    look(mk_ea(e_seg(1, 0), e_api(1, 0), e_ext(1, 0) ^ 1, 1, 4), 0, 0, MISS, "R3 extra bits");
    look(mk_ea(e_seg(1, 0), e_api(1, 0), e_ext(1, 0), 2, 4), 0, 0, MISS, "R2 R3 other set");

    // R1: rewriting a segment register changes the compared identifier
    wr_seg(e_seg(3, 0), s_vsid(15) ^ 24'h800000, 1'b0, 1'b0);
    look(mk_ea(e_seg(3, 0), e_api(3, 0), e_ext(3, 0), 3, 7), 0, 0, MISS, "R1 R3 segment rewrite");
    wr_seg(e_seg(3, 0), s_vsid(e_seg(3, 0)), e_seg(3, 0) & 1, (e_seg(3, 0) >> 1) & 1);
    look(mk_ea(e_seg(3, 0), e_api(3, 0), e_ext(3, 0), 3, e_off(3, 0)), 0, 0,
         exp_ent(3, 0, 0, 0), "R1 segment restored");

    // R9: kill set 2, neighbours stay
    kill_set(2);
    for (int w = 0; w < 2; w++)
      look(mk_ea(e_seg(2, w), e_api(2, w), e_ext(2, w), 2, 1), 0, 0, MISS, "R9 killed set");
    look(mk_ea(e_seg(3, 1), e_api(3, 1), e_ext(3, 1), 3, e_off(3, 1)), 2, 1,
         exp_ent(3, 1, 2, 1), "R9 neighbour set");
    look(mk_ea(e_seg(1, 1), e_api(1, 1), e_ext(1, 1), 1, e_off(1, 1)), 0, 0,
         exp_ent(1, 1, 0, 0), "R9 neighbour set");

    // R8: set 5, last use was way 1; hit way 0 makes way 1 the victim
    look(mk_ea(e_seg(5, 0), e_api(5, 0), e_ext(5, 0), 5, e_off(5, 0)), 0, 0,
         exp_ent(5, 0, 0, 0), "R8 touch way0");
    ea_a = mk_ea(7, 60, 1, 5, 0);
    wr_ent(ea_a, 1'b0, 1'b1, s_vsid(7), 32'hCAFE0, 1, 5, 2);
    look(mk_ea(e_seg(5, 1), e_api(5, 1), e_ext(5, 1), 5, 3), 0, 0, MISS, "R8 way1 replaced");
    look(mk_ea(e_seg(5, 0), e_api(5, 0), e_ext(5, 0), 5, e_off(5, 0)), 0, 0,
         exp_ent(5, 0, 0, 0), "R8 way0 kept");
    look(ea_a | 32'h123, 1, 0, expv(1'b1, 2, 1, 1, 1, 32'hCAFE0, 5, 32'h123), "R8 new entry");
    // last use now the new entry in way 1 -> next victim way 0
    ea_b = mk_ea(9, 61, 2, 5, 0);
    wr_ent(ea_b, 1'b1, 1'b1, s_vsid(9), 32'hBEEF1, 1, 9, 2);
    look(mk_ea(e_seg(5, 0), e_api(5, 0), e_ext(5, 0), 5, 3), 0, 0, MISS, "R8 way0 replaced");
    look(ea_b | 32'h0AB, 0, 1, expv(1'b1, 2, 1, 0, 0, 32'hBEEF1, 9, 32'h0AB), "R8 second entry");
    look(ea_a | 32'hFFF, 2, 0, expv(1'b1, 2, 1, 1, 2, 32'hCAFE0, 5, 32'hFFF), "R8 first entry kept");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule